// File: doc/BRIEF.md
# Per-Pin Standby Hold Status Register

This block keeps a 16-bit record of which pins of one I/O port are being held in their last state while the chip sits in a low-power standby period. When the standby-entry pulse arrives, hardware marks every pin whose hold-enable input is high. Software acknowledges a marked pin by writing 0 to its bit. Writing 1 to a bit leaves it as it was.

The register is reached over a small register bus with separate write and read strobes. Each access carries a secure attribute and a privileged attribute. Every bit has its own secure-attribute input. Two protection inputs restrict unprivileged accesses: one covers the secure bits and one covers the non-secure bits. A bit that an access may not touch reads as 0 and ignores the write. The block has no error or fault output, so a blocked access is silently absorbed. Read data is returned one cycle after the read strobe as a 32-bit word. Bits 31 to 16 of that word are always 0.

Top module: `ret_status_reg`

## Requirements
- R1: While `rst_n` is low and after it is released, `ret_active` is 0, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: On a clock edge with `standby_enter` high, each bit of `ret_active` whose `ret_en` bit is 1 becomes 1. Without `standby_enter`, no bit of `ret_active` rises.
- R3: A write that is allowed on bit i clears that bit when `bus_wdata[i]` is 0 and leaves it unchanged when `bus_wdata[i]` is 1. Without a write, no bit falls.
- R4: If the hardware set and a software clear hit the same bit on the same edge, the bit ends up 1.
- R5: For a bit with `pin_secure[i]` = 1, an access with `bus_secure` = 0 reads 0 for that bit and its write is ignored. No fault of any kind is signalled.
- R6: With `spriv_prot` = 1, an access with `bus_priv` = 0 reads 0 from a secure bit and cannot clear it, even when `bus_secure` = 1.
- R7: With `nspriv_prot` = 1, an access with `bus_priv` = 0 reads 0 from a non-secure bit (`pin_secure[i]` = 0) and cannot clear it. A privileged access is not affected.
- R8: `bus_rvalid` is 1 exactly in the cycle after a cycle with `bus_rd` = 1. `bus_rdata[15:0]` then holds the bits as they were before that edge, masked by the access rules. `bus_rdata[31:16]` is always 0, and `bus_rdata` is 0 whenever `bus_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| standby_enter | input | 1 | Single-cycle pulse marking standby entry |
| ret_en | input | 16 | Per-pin hold enable |
| pin_secure | input | 16 | Per-pin secure attribute |
| spriv_prot | input | 1 | Restrict unprivileged access to secure bits |
| nspriv_prot | input | 1 | Restrict unprivileged access to non-secure bits |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data; 0 clears a bit |
| bus_rd | input | 1 | Read strobe |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Masked read data |
| bus_rvalid | output | 1 | Read data valid |
| ret_active | output | 16 | Live status bits to the pad hold logic |

## Verification
The status bits drive `ret_active` directly. A wrong set, a missed clear or a leaked write therefore shows at that port on the edge right after the offending cycle. A masking error shows only on a read, one cycle after the strobe, and only for the attribute combination that exposes it. For that reason the stimulus steps through every mix of secure, privileged and protection inputs, with mixed per-pin secure patterns, so that each masking path is read back within a few cycles.

// File: rtl/ret_pkg.sv
package ret_pkg;

  // Attributes carried by one bus access.
  typedef struct packed {
    logic secure;
    logic priv;
  } ret_attr_t;

  // Decide whether one access may see and modify one status bit.
  function automatic logic ret_bit_allowed(
    input logic      pin_sec,
    input ret_attr_t attr,
    input logic      sprot,
    input logic      nsprot
  );
    logic ok;
    if (pin_sec) begin
      ok = attr.secure && !(sprot && !attr.priv);
    end else begin
      ok = !(nsprot && !attr.priv);
    end
    return ok;
  endfunction

endpackage

// File: rtl/ret_access_mask.sv
module ret_access_mask
  import ret_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic [N_PINS-1:0] pin_secure,
  input  ret_attr_t         attr,
  input  logic              sprot,
  input  logic              nsprot,
  output logic [N_PINS-1:0] allow
);

  for (genvar g = 0; g < N_PINS; g++) begin : g_bit
    always_comb begin
      allow[g] = ret_bit_allowed(pin_secure[g], attr, sprot, nsprot);
    end
  end

endmodule

// File: rtl/ret_bit_cell.sv
module ret_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  logic bit_en;
  logic bit_d;

  // Set has priority over clear.
  always_comb begin
    bit_en = set_i | clr_i;
    bit_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (bit_en) begin
      q <= bit_d;
    end
  end

endmodule

// File: rtl/ret_read_port.sv
module ret_read_port #(
  parameter int N_PINS = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [N_PINS-1:0] state,
  input  logic [N_PINS-1:0] allow,
  output logic [BUS_W-1:0]  rdata,
  output logic              rvalid
);

  localparam int PAD_W = BUS_W - N_PINS;

  logic [BUS_W-1:0] rdata_d;
  logic             rvalid_d;
  logic             rd_en;

  always_comb begin
    rvalid_d = rd;
    rdata_d  = '0;
    if (rd) begin
      rdata_d = {{PAD_W{1'b0}}, state & allow};
    end
    rd_en = rd | rvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/ret_status_reg.sv
module ret_status_reg
  import ret_pkg::*;
#(
  parameter int N_PINS = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_enter,
  input  logic [N_PINS-1:0] ret_en,
  input  logic [N_PINS-1:0] pin_secure,
  input  logic              spriv_prot,
  input  logic              nspriv_prot,
  input  logic              bus_wr,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_secure,
  input  logic              bus_priv,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic [N_PINS-1:0] ret_active
);

  ret_attr_t         attr;
  logic [N_PINS-1:0] allow;
  logic [N_PINS-1:0] hw_set;
  logic [N_PINS-1:0] sw_clr;

  always_comb begin
    attr.secure = bus_secure;
    attr.priv   = bus_priv;
    hw_set      = ret_en & {N_PINS{standby_enter}};
    sw_clr      = allow & ~bus_wdata & {N_PINS{bus_wr}};
  end

  ret_access_mask #(.N_PINS(N_PINS)) u_mask (
    .pin_secure (pin_secure),
    .attr       (attr),
    .sprot      (spriv_prot),
    .nsprot     (nspriv_prot),
    .allow      (allow)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_cell
    ret_bit_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hw_set[g]),
      .clr_i (sw_clr[g]),
      .q     (ret_active[g])
    );
  end

  ret_read_port #(.N_PINS(N_PINS), .BUS_W(BUS_W)) u_rport (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .state  (ret_active),
    .allow  (allow),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

endmodule

// File: rtl/ret_status_chk.sv
module ret_status_chk #(
  parameter int N_PINS = 16,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_enter,
  input logic [N_PINS-1:0] ret_en,
  input logic [N_PINS-1:0] pin_secure,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_secure,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              bus_rvalid,
  input logic [N_PINS-1:0] ret_active
);

  // R2
  set_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_enter |=> ((ret_active & $past(ret_en)) == $past(ret_en)));

  // R2
  no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_enter |=> ((ret_active & ~$past(ret_active)) == '0));

  // R3
  no_fall_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((~ret_active & $past(ret_active)) == '0));

  // R5
  ns_write_secure_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_secure && !standby_enter)
      |=> (((ret_active ^ $past(ret_active)) & $past(pin_secure)) == '0));

  // R5
  ns_read_secure_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_secure) |=> ((bus_rdata[N_PINS-1:0] & $past(pin_secure)) == '0));

  // R8
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R8
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:N_PINS] == '0);

  // R8
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> (bus_rdata == '0));

endmodule

bind ret_status_reg ret_status_chk #(.N_PINS(N_PINS), .BUS_W(BUS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .standby_enter (standby_enter),
  .ret_en        (ret_en),
  .pin_secure    (pin_secure),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_secure    (bus_secure),
  .bus_rdata     (bus_rdata),
  .bus_rvalid    (bus_rvalid),
  .ret_active    (ret_active)
);

// File: tb/ret_status_reg_tb.sv
module ret_status_reg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        standby_enter;
  logic [15:0] ret_en;
  logic [15:0] pin_secure;
  logic        spriv_prot;
  logic        nspriv_prot;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic        bus_rd;
  logic        bus_secure;
  logic        bus_priv;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] ret_active;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  logic [15:0] model;
  logic        exp_rvalid;
  logic [31:0] exp_rdata;

  ret_status_reg u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .standby_enter (standby_enter),
    .ret_en        (ret_en),
    .pin_secure    (pin_secure),
    .spriv_prot    (spriv_prot),
    .nspriv_prot   (nspriv_prot),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rd        (bus_rd),
    .bus_secure    (bus_secure),
    .bus_priv      (bus_priv),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .ret_active    (ret_active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] allow_mask(input logic [15:0] ps, input logic sec,
                                             input logic priv, input logic sp, input logic nsp);
    logic [15:0] a;
    for (int i = 0; i < 16; i++) begin
      if (ps[i]) a[i] = sec && (priv || !sp);
      else       a[i] = priv || !nsp;
    end
    return a;
  endfunction

  // Reference model: per-cycle behaviour from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model      = 16'h0;
      exp_rvalid = 1'b0;
      exp_rdata  = 32'h0;
    end else begin
      logic [15:0] a;
      logic [15:0] clr;
      logic [15:0] set;
      a          = allow_mask(pin_secure, bus_secure, bus_priv, spriv_prot, nspriv_prot);
      exp_rvalid = bus_rd;
      exp_rdata  = bus_rd ? {16'h0, model & a} : 32'h0;
      clr        = bus_wr ? (a & ~bus_wdata) : 16'h0;
      set        = standby_enter ? ret_en : 16'h0;
      model      = (model & ~clr) | set;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "ret_active", {16'h0, ret_active}, {16'h0, model});
      chk("R8", "bus_rvalid", {31'h0, bus_rvalid}, {31'h0, exp_rvalid});
      chk(cur_req, "bus_rdata", bus_rdata, exp_rdata);
    end
  end

  task automatic step(input logic rd, input logic wr, input logic [15:0] wd,
                      input logic sec, input logic priv, input logic stby);
    bus_rd        = rd;
    bus_wr        = wr;
    bus_wdata     = wd;
    bus_secure    = sec;
    bus_priv      = priv;
    standby_enter = stby;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ret_en = 16'h0; pin_secure = 16'h0; spriv_prot = 1'b0; nspriv_prot = 1'b0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 16'hFFFF;
    bus_secure = 1'b0; bus_priv = 1'b0; standby_enter = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1", "reset ret_active", {16'h0, ret_active}, 32'h0);
    chk("R1", "reset rvalid", {31'h0, bus_rvalid}, 32'h0);
    chk("R1", "reset rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    idle();
    chk("R1", "post reset ret_active", {16'h0, ret_active}, 32'h0);

    // R2: hardware set
    cur_req = "R2";
    ret_en = 16'hA5C3;
    step(1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1, 1'b1);
    chk("R2", "set pattern", {16'h0, ret_active}, 32'h0000A5C3);
    ret_en = 16'h0F00;
    idle();
    chk("R2", "no set without pulse", {16'h0, ret_active}, 32'h0000A5C3);
    step(1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1, 1'b1);
    chk("R2", "second set", {16'h0, ret_active}, 32'h0000AFC3);

    // R3: software clear, write 1 no effect
    cur_req = "R3";
    step(1'b0, 1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b0);
    chk("R3", "write ones", {16'h0, ret_active}, 32'h0000AFC3);
    step(1'b1, 1'b1, 16'hFF00, 1'b1, 1'b1, 1'b0);
    // R8: read in same cycle as write sees the old value
    chk("R8", "read before clear", bus_rdata, 32'h0000AFC3);
    chk("R3", "clear low byte", {16'h0, ret_active}, 32'h0000AF00);

    // R4: set beats clear
    cur_req = "R4";
    ret_en = 16'h8001;
    step(1'b0, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b1);
    chk("R4", "set wins", {16'h0, ret_active}, 32'h00008001);
    ret_en = 16'hFFFF;
    step(1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1);

    // R5: secure pins versus non-secure access
    cur_req = "R5";
    pin_secure = 16'h00FF;
    step(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b0);
    chk("R5", "ns read masked", bus_rdata, 32'h0000FF00);
    step(1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0);
    chk("R5", "ns write only hits ns bits", {16'h0, ret_active}, 32'h000000FF);
    step(1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b1, 1'b0);
    chk("R5", "secure read sees all", bus_rdata, 32'h000000FF);

    // R6: secure privilege protection
    cur_req = "R6";
    spriv_prot = 1'b1;
    step(1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0);
    chk("R6", "unpriv secure read", bus_rdata, 32'h0000FF00);
    chk("R6", "unpriv secure write", {16'h0, ret_active}, 32'h000000FF);
    step(1'b0, 1'b1, 16'h00F0, 1'b1, 1'b1, 1'b0);
    chk("R6", "priv secure write", {16'h0, ret_active}, 32'h000000F0);
    spriv_prot = 1'b0;

    // R7: non-secure privilege protection
    cur_req = "R7";
    nspriv_prot = 1'b1;
    step(1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0);
    chk("R7", "unpriv read of ns bits", bus_rdata, 32'h000000FF);
    chk("R7", "unpriv write keeps ns bits", {16'h0, ret_active}, 32'h0000FF00);
    step(1'b0, 1'b1, 16'h0F0F, 1'b0, 1'b1, 1'b0);
    chk("R7", "priv ns write", {16'h0, ret_active}, 32'h00000F00);
    nspriv_prot = 1'b0;

    // R8 and mixed patterns: model comparison every cycle
    cur_req = "R8";
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      ret_en      = $urandom;
      pin_secure  = $urandom;
      spriv_prot  = r[8];
      nspriv_prot = r[9];
      step(r[0], r[1], $urandom, r[2], r[3], (r[7:4] == 4'h0));
    end
    idle();
    idle();
    finish_run();
  end

endmodule